// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block steers instruction fetch for tight loops so that looping costs no branch instructions and no cycles. It watches each issued program address together with decoded loop commands. One command repeats the next issued instruction a counted number of times. Another opens a block loop whose body runs from the address after the command up to and including a given end address. Two block levels can nest: an outer loop with its own counter and an inner loop with a second counter.

Software loads each counter with the iteration count minus one through a separate write port before the loop starts. Each cycle the block tells the fetch unit one of three things: fetch the next sequential address, fetch a loop start address (redirect), or issue the same instruction again (hold). It also reports how deeply nested the current block loop is. Each active level keeps its own start address, end address and counter, so the outer loop resumes correctly after the inner loop finishes.

Top module: `zol_seq`

## Requirements
- R1: After reset, level_o is 0 (no loop), and hold_o and redirect_o are 0.
- R2: A single-repeat command issued with count c > 0 makes the next issued instruction issue c+1 times in a row. hold_o is 1 on the first c of those issues and 0 on the last.
- R3: A single-repeat command with count 0 makes the next instruction issue once, with hold_o at 0.
- R4: A block command issued at address p with end address e opens a loop with start p+1 and end e. It raises level_o from 0 to 1 (outer, counter select 0) or from 1 to 2 (inner, counter select 1) on the next cycle.
- R5: When the address issued at the active level's end address finds that level's counter nonzero, redirect_o is 1 with redirect_pc_o equal to that level's start address. The counter then decrements.
- R6: When the address issued at the active level's end address finds that level's counter zero, redirect_o is 0 and level_o drops by one on the next cycle.
- R7: After the inner loop exits, the outer loop still redirects at its own end address to its own start address.
- R8: A counter write with select 0 loads the outer counter and select 1 loads the inner counter. The value, written as count minus one, takes effect from the next cycle.
- R9: A block command issued while level_o is 2 is ignored: the level and the saved addresses are unchanged.
- R10: While hold_o is 1, redirect_o is 0 and level_o does not change. A block end check happens only on the last issue of a repeated instruction.
- R11: A counter value of all ones (2^CW - 1) gives 2^CW passes without wrapping.
- R12: With pc_valid_i at 0, redirect_o and hold_o are 0 and no loop state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_valid_i | input | 1 | An instruction at pc_i issues this cycle |
| pc_i | input | AW | Address of the issuing instruction |
| rpt_cmd_i | input | 1 | Issuing instruction is a single-repeat command |
| rpt_cnt_i | input | CW | Repeat count minus one |
| blk_cmd_i | input | 1 | Issuing instruction opens a block loop |
| blk_end_i | input | AW | End address of the block loop (inclusive) |
| cnt_wr_i | input | 1 | Block counter write strobe |
| cnt_sel_i | input | 1 | Counter select: 0 outer, 1 inner |
| cnt_data_i | input | CW | Value written (count minus one) |
| redirect_o | output | 1 | Next fetch address is redirect_pc_o |
| redirect_pc_o | output | AW | Loop start address to fetch next |
| hold_o | output | 1 | Issue the same instruction again |
| level_o | output | 2 | Active loop depth: 0 none, 1 outer, 2 inner |

## Verification
Assertions check every cycle that hold and redirect never coincide and that the depth stays in range. They also check that an idle issue slot changes nothing, that the depth steps correctly on a block command, and that it stays put on a redirect or a hold. Only the bench's fetch-model scenarios can show the iteration counts. They sweep nested counts and repeat counts, including all-ones counts, a repeat of the inner end instruction, and an ignored third nesting level. These scenarios show how often each address issues and that the outer loop resumes at its own start.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int unsigned NUM_LVL = 2;
  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_OUTER = 2'd1,
    LVL_INNER = 2'd2
  } lvl_e;
endpackage

// File: rtl/zol_rpt_unit.sv
module zol_rpt_unit #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          cmd_i,
  input  logic [CW-1:0] cnt_i,
  output logic          hold_o
);
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_nz;

  assign cnt_nz = (cnt_q != '0);
  assign hold_o = issue_i & armed_q & cnt_nz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (issue_i) begin
      if (armed_q) begin
        // target instruction issuing: count down, disarm on last issue
        if (cnt_nz) cnt_q <= cnt_q - 1'b1;
        else        armed_q <= 1'b0;
      end else if (cmd_i) begin
        armed_q <= 1'b1;
        cnt_q   <= cnt_i;
      end
    end
  end
endmodule

// File: rtl/zol_blk_level.sv
module zol_blk_level #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          push_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic          step_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o,
  output logic          zero_o
);
  logic [AW-1:0] start_q, end_q;
  logic [CW-1:0] cnt_q;

  assign start_o = start_q;
  assign end_o   = end_q;
  assign zero_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (push_i) begin
      start_q <= start_i;
      end_q   <= end_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (wr_i)              cnt_q <= wr_data_i;
    else if (step_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pc_valid_i,
  input  logic [AW-1:0] pc_i,
  input  logic          rpt_cmd_i,
  input  logic [CW-1:0] rpt_cnt_i,
  input  logic          blk_cmd_i,
  input  logic [AW-1:0] blk_end_i,
  input  logic          cnt_wr_i,
  input  logic          cnt_sel_i,
  input  logic [CW-1:0] cnt_data_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          hold_o,
  output logic [1:0]    level_o
);
  localparam int unsigned LW = $clog2(NUM_LVL);

  lvl_e          lvl_q;
  logic          hold;
  logic          active;
  logic [LW-1:0] cur;
  logic [LW-1:0] nxt;
  logic          at_end, push, pop;

  logic [AW-1:0] lvl_start [NUM_LVL];
  logic [AW-1:0] lvl_end   [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_zero;

  zol_rpt_unit #(.CW(CW)) u_rpt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (pc_valid_i),
    .cmd_i   (rpt_cmd_i),
    .cnt_i   (rpt_cnt_i),
    .hold_o  (hold)
  );

  assign active = (lvl_q != LVL_NONE);
  assign cur    = active ? LW'(lvl_q - 2'd1) : '0;
  assign nxt    = LW'(lvl_q);
  assign at_end = pc_valid_i & active & ~hold & (pc_i == lvl_end[cur]);
  assign pop    = at_end & lvl_zero[cur];
  assign push   = pc_valid_i & blk_cmd_i & ~hold & ~at_end & (lvl_q != LVL_INNER);

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    zol_blk_level #(.AW(AW), .CW(CW)) u_lvl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (cnt_wr_i && (cnt_sel_i == 1'(k))),
      .wr_data_i (cnt_data_i),
      .push_i    (push && (nxt == LW'(k))),
      .start_i   (pc_i + 1'b1),
      .end_i     (blk_end_i),
      .step_i    (at_end && (cur == LW'(k))),
      .start_o   (lvl_start[k]),
      .end_o     (lvl_end[k]),
      .zero_o    (lvl_zero[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lvl_q <= LVL_NONE;
    else if (push) lvl_q <= lvl_e'(lvl_q + 2'd1);
    else if (pop)  lvl_q <= lvl_e'(lvl_q - 2'd1);
  end

  assign redirect_o    = at_end & ~lvl_zero[cur];
  assign redirect_pc_o = lvl_start[cur];
  assign hold_o        = hold;
  assign level_o       = lvl_q;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pc_valid_i,
  input logic       blk_cmd_i,
  input logic       redirect_o,
  input logic       hold_o,
  input logic [1:0] level_o
);
  a_r1_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= 2'd2);

  a_r10_hold_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !redirect_o);

  a_r10_hold_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> level_o == $past(level_o));

  a_r5_redirect_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> level_o == $past(level_o));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_valid_i |-> (!redirect_o && !hold_o));

  a_r12_idle_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_valid_i |=> level_o == $past(level_o));

  a_r4_enter_outer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd0 && pc_valid_i && blk_cmd_i && !hold_o) |=> level_o == 2'd1);

  a_r9_third_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd2 && pc_valid_i && blk_cmd_i && !hold_o && redirect_o) |=> level_o == 2'd2);
endmodule

bind zol_seq zol_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_valid_i (pc_valid_i),
  .blk_cmd_i  (blk_cmd_i),
  .redirect_o (redirect_o),
  .hold_o     (hold_o),
  .level_o    (level_o)
);

// File: tb/zol_seq_tb.sv
module zol_seq_tb;
  localparam int unsigned AW = 8;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pc_valid_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          rpt_cmd_i = 1'b0;
  logic [CW-1:0] rpt_cnt_i = '0;
  logic          blk_cmd_i = 1'b0;
  logic [AW-1:0] blk_end_i = '0;
  logic          cnt_wr_i = 1'b0;
  logic          cnt_sel_i = 1'b0;
  logic [CW-1:0] cnt_data_i = '0;
  logic          redirect_o;
  logic [AW-1:0] redirect_pc_o;
  logic          hold_o;
  logic [1:0]    level_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  zol_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pc_valid_i(pc_valid_i), .pc_i(pc_i),
    .rpt_cmd_i(rpt_cmd_i), .rpt_cnt_i(rpt_cnt_i), .blk_cmd_i(blk_cmd_i),
    .blk_end_i(blk_end_i), .cnt_wr_i(cnt_wr_i), .cnt_sel_i(cnt_sel_i),
    .cnt_data_i(cnt_data_i), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .hold_o(hold_o), .level_o(level_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; pc_valid_i = 1'b0; rpt_cmd_i = 1'b0; blk_cmd_i = 1'b0; cnt_wr_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive one issue slot at a negedge, outputs sampled 1 ns later
  task automatic cyc(input logic [AW-1:0] pc, input logic v, input logic rp,
                     input logic [CW-1:0] rc, input logic bk, input logic [AW-1:0] be,
                     input logic wr, input logic sel, input logic [CW-1:0] wd);
    @(negedge clk);
    pc_i = pc; pc_valid_i = v; rpt_cmd_i = rp; rpt_cnt_i = rc;
    blk_cmd_i = bk; blk_end_i = be; cnt_wr_i = wr; cnt_sel_i = sel; cnt_data_i = wd;
    #1;
  endtask

  // program: 0 wr outer=a, 1 block end 8, 2 wr inner=b, 3 block end 6,
  // 4/5 repeat r (at 4 targeting 5, or in variant at 5 targeting end 6), 7 outer body, 9 exit
  task automatic run_prog(input int a, input int b, input int r, input bit variant);
    int exec [16];
    int guard;
    logic [AW-1:0] pc;
    logic rp, bk, wr, sel;
    logic [AW-1:0] be;
    logic [CW-1:0] wd;
    for (int i = 0; i < 16; i++) exec[i] = 0;
    do_reset();
    pc = '0;
    guard = 0;
    while (pc != 9 && guard < 20000) begin
      rp = 0; bk = 0; wr = 0; sel = 0; be = '0; wd = '0;
      case (pc)
        0: begin wr = 1; sel = 0; wd = CW'(a); end
        1: begin bk = 1; be = 8; end
        2: begin wr = 1; sel = 1; wd = CW'(b); end
        3: begin bk = 1; be = 6; end
        4: rp = !variant;
        5: rp = variant;
        default: ;
      endcase
      cyc(pc, 1'b1, rp, CW'(r), bk, be, wr, sel, wd);
      exec[pc]++;
      if (redirect_o) begin
        if (pc == 6) chk(redirect_pc_o == 4, "R5 inner redirect target", redirect_pc_o, 4);
        else chk(pc == 8 && redirect_pc_o == 2, "R7 outer redirect target", redirect_pc_o, 2);
      end
      if (pc == 5 && !hold_o) chk(level_o == 2, "R4 inner level", level_o, 2);
      if (pc == 7) chk(level_o == 1, "R6 back to outer level", level_o, 1);
      if (redirect_o)  pc = redirect_pc_o;
      else if (!hold_o) pc = pc + 1'b1;
      guard++;
    end
    chk(guard < 20000, "R5 loop terminates", guard, 0);
    cyc(pc, 1'b1, 0, '0, 0, '0, 0, 0, '0);
    chk(level_o == 0, "R6 exit to no loop", level_o, 0);
    chk(exec[2] == a + 1, "R7 outer body passes", exec[2], a + 1);
    chk(exec[8] == a + 1, "R8 outer end passes", exec[8], a + 1);
    if (variant) begin
      chk(exec[6] == (a + 1) * (b + 1) * (r + 1), "R10 repeated end issues", exec[6], (a + 1) * (b + 1) * (r + 1));
      chk(exec[5] == (a + 1) * (b + 1), "R10 repeat cmd issues", exec[5], (a + 1) * (b + 1));
    end else begin
      chk(exec[6] == (a + 1) * (b + 1), "R8 inner end passes", exec[6], (a + 1) * (b + 1));
      if (r == 0) chk(exec[5] == (a + 1) * (b + 1), "R3 single issue", exec[5], (a + 1) * (b + 1));
      else chk(exec[5] == (a + 1) * (b + 1) * (r + 1), "R2 repeated issues", exec[5], (a + 1) * (b + 1) * (r + 1));
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    chk(level_o == 0 && !hold_o, "R1 reset level/hold", level_o, 0);
    chk(!redirect_o, "R1 reset redirect", redirect_o, 0);
    rst_ni = 1'b1;

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 3; r++) begin
          run_prog(a, b, r, 1'b0);
          run_prog(a, b, r, 1'b1);
        end
    run_prog(15, 15, 15, 1'b0); // R11 all-ones counts
    run_prog(15, 0, 0, 1'b1);   // R11

    // R9: third block command ignored; R12: idle slot changes nothing
    do_reset();
    cyc(0, 1, 0, '0, 0, '0, 1, 0, 4'd3);
    cyc(1, 1, 0, '0, 1, 8'd20, 0, 0, '0);
    cyc(2, 1, 0, '0, 1, 8'd10, 0, 0, '0);
    cyc(3, 1, 0, '0, 1, 8'd5, 0, 0, '0);
    cyc(4, 1, 0, '0, 0, '0, 0, 0, '0);
    chk(level_o == 2, "R9 level stays inner", level_o, 2);
    cyc(5, 1, 0, '0, 0, '0, 0, 0, '0);
    chk(!redirect_o && level_o == 2, "R9 ignored end not used", redirect_o, 0);
    cyc(10, 0, 0, '0, 0, '0, 0, 0, '0);
    chk(!redirect_o && !hold_o, "R12 idle slot quiet", redirect_o, 0);
    cyc(11, 1, 0, '0, 0, '0, 0, 0, '0);
    chk(level_o == 2, "R12 idle slot kept level", level_o, 2);
    cyc(10, 1, 0, '0, 0, '0, 0, 0, '0);
    chk(!redirect_o, "R6 inner zero count exits", redirect_o, 0);
    cyc(20, 1, 0, '0, 0, '0, 0, 0, '0);
    chk(level_o == 1 && redirect_o && redirect_pc_o == 2, "R7 outer resumes", redirect_pc_o, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule